// File: doc/BRIEF.md
# Processor Bus Command Generator

This block watches a 3-bit processor status bus and turns each machine cycle it announces into bus strobes. A machine cycle starts when the sampled status leaves the passive code and ends when the passive code is sampled again. For each cycle the block gives one address latch enable pulse, then one of five active-high commands (memory read, memory write, I/O read, I/O write, interrupt acknowledge). It also gives an enable and a direction for an external data transceiver, and a dual-purpose output. All outputs are active high, except that the direction output is high for transmit (write).

The block has two modes. In system-bus mode (`io_bus_mode` low), an arbitration input `bus_release` takes the commands off the bus by lowering `cmd_oe`. Once that input falls, commands come back only after a settling time. In this mode the dual-purpose output is a cascade enable, raised with the address latch pulse of the second cycle of an interrupt-acknowledge pair. In I/O-bus mode (`io_bus_mode` high), `bus_release` is ignored, and the dual-purpose output becomes the data enable for the peripheral side: I/O and acknowledge cycles. `xcvr_en` then serves memory cycles only. A qualifier input `cmd_qual` forces every command and data enable inactive while still driving them.

Top module: `bus_cmd_gen`

## Requirements
- R1: Status codes are 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 code fetch, 101 memory read, 110 memory write, 111 passive. When the status sampled at a rising edge is non-passive and no cycle is open, `ale` is high for exactly that one following clock, once per machine cycle.
- R2: On the clock after the `ale` clock, the command for the latched status goes high and stays high until passive status is sampled. Code fetch gives memory read. Halt and passive give no command. At most one command is high at a time.
- R3: `xcvr_dir` is low while a read, fetch or acknowledge cycle is open (from the `ale` clock to its end) and high otherwise.
- R4: For writes, the data enable rises with the command. For reads, fetches and acknowledges, it rises one clock after the command. It drops when the command ends.
- R5: With `cmd_qual` low, all commands and data enables are low in the same cycle, and `cmd_oe` is unchanged.
- R6: In system-bus mode, `bus_release` high gives `cmd_oe` low and holds all commands and data enables low at once.
- R7: In system-bus mode, after `bus_release` falls, commands and data enables stay inactive for SETTLE_CLKS (default 2) rising edges and become active at the second one.
- R8: In system-bus mode, `cas_or_pden` stays low in the first acknowledge cycle of a pair. It is high together with `ale` in the acknowledge cycle that directly follows it. `int_ack` is given in both cycles, and any other cycle in between restarts the pair.
- R9: In I/O-bus mode, `cmd_oe` is high and `bus_release` is ignored. `cas_or_pden` is the data enable for I/O and acknowledge cycles, and `xcvr_en` is the data enable for memory and fetch cycles only.
- R10: During and right after reset no cycle is open. All commands, `ale`, data enables and `cas_or_pden` are low, and `xcvr_dir` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; status is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| status | input | 3 | Processor bus status code |
| io_bus_mode | input | 1 | High selects I/O-bus mode, low system-bus mode |
| bus_release | input | 1 | System-bus mode: high releases the commands |
| cmd_qual | input | 1 | Low forces commands and data enables inactive |
| ale | output | 1 | Address latch enable pulse |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| io_rd | output | 1 | I/O read command |
| io_wr | output | 1 | I/O write command |
| int_ack | output | 1 | Interrupt acknowledge command |
| cmd_oe | output | 1 | Output enable of the command lines |
| xcvr_en | output | 1 | Transceiver data enable |
| xcvr_dir | output | 1 | Transceiver direction, high for transmit |
| cas_or_pden | output | 1 | Cascade enable or peripheral data enable |

## Verification
The assertions check on every cycle these rules: at most one command is high, `ale` never lasts two clocks, the qualifier and the release input block the commands, the cascade enable occurs only with `ale`, and commands stay inactive on the clock after the release input falls. Only the bench scenarios can show the rest. That covers the cycle-by-cycle placement of `ale`, the command and the data enable for each status code, and the direction level. It also covers the exact clock on which commands resume after settling, the first/second pairing of acknowledge cycles, and the routing of data enables between the two outputs in I/O-bus mode.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;

    typedef enum logic [2:0] {
        ST_INTA  = 3'b000,
        ST_IORD  = 3'b001,
        ST_IOWR  = 3'b010,
        ST_HALT  = 3'b011,
        ST_FETCH = 3'b100,
        ST_MEMRD = 3'b101,
        ST_MEMWR = 3'b110,
        ST_PASS  = 3'b111
    } bus_stat_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_XFER = 2'd2
    } phase_e;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
        logic inta;
        logic xfer;
        logic rx;
        logic io_side;
    } kind_dec_t;

    typedef struct packed {
        phase_e    phase;
        bus_stat_e kind;
        logic      age;
        logic      second;
        logic      ack_pend;
    } seq_t;

endpackage

// File: rtl/bus_cmd_decode.sv
module bus_cmd_decode
    import bus_cmd_pkg::*;
(
    input  bus_stat_e kind,
    output kind_dec_t dec
);
    always_comb begin
        dec = '0;
        case (kind)
            ST_INTA:  begin dec.inta   = 1'b1; dec.xfer = 1'b1; dec.rx = 1'b1; dec.io_side = 1'b1; end
            ST_IORD:  begin dec.io_rd  = 1'b1; dec.xfer = 1'b1; dec.rx = 1'b1; dec.io_side = 1'b1; end
            ST_IOWR:  begin dec.io_wr  = 1'b1; dec.xfer = 1'b1; dec.io_side = 1'b1; end
            ST_FETCH: begin dec.mem_rd = 1'b1; dec.xfer = 1'b1; dec.rx = 1'b1; end
            ST_MEMRD: begin dec.mem_rd = 1'b1; dec.xfer = 1'b1; dec.rx = 1'b1; end
            ST_MEMWR: begin dec.mem_wr = 1'b1; dec.xfer = 1'b1; end
            default:  dec = '0;
        endcase
    end
endmodule

// File: rtl/bus_cmd_settle.sv
module bus_cmd_settle #(
    parameter int SETTLE_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic release_in,
    output logic ready
);
    localparam int CNT_W = $clog2(SETTLE_CLKS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CLKS);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (release_in)
            cnt_d = '0;
        else if (cnt_q != CNT_MAX)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == CNT_MAX) && !release_in;

    // R7: no readiness on the clock right after release falls
    a_r7_settle_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (!release_in && $past(release_in)) |-> !ready);
endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
    import bus_cmd_pkg::*;
#(
    parameter int SETTLE_CLKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] status,
    input  logic       io_bus_mode,
    input  logic       bus_release,
    input  logic       cmd_qual,
    output logic       ale,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       io_rd,
    output logic       io_wr,
    output logic       int_ack,
    output logic       cmd_oe,
    output logic       xcvr_en,
    output logic       xcvr_dir,
    output logic       cas_or_pden
);
    seq_t      seq_d, seq_q;
    kind_dec_t dec;
    bus_stat_e stat_in;
    logic      settle_ready;
    logic      cmd_ok;
    logic      in_xfer;
    logic      de_raw;

    assign stat_in = bus_stat_e'(status);

    bus_cmd_decode u_decode (
        .kind (seq_q.kind),
        .dec  (dec)
    );

    bus_cmd_settle #(.SETTLE_CLKS(SETTLE_CLKS)) u_settle (
        .clk        (clk),
        .rst_n      (rst_n),
        .release_in (bus_release),
        .ready      (settle_ready)
    );

    always_comb begin
        seq_d = seq_q;
        case (seq_q.phase)
            PH_IDLE: begin
                if (stat_in != ST_PASS) begin
                    seq_d.phase    = PH_ADDR;
                    seq_d.kind     = stat_in;
                    seq_d.age      = 1'b0;
                    seq_d.second   = seq_q.ack_pend && (stat_in == ST_INTA);
                    seq_d.ack_pend = 1'b0;
                end
            end
            PH_ADDR: begin
                seq_d.age   = 1'b0;
                seq_d.phase = (stat_in == ST_PASS) ? PH_IDLE : PH_XFER;
            end
            PH_XFER: begin
                if (stat_in == ST_PASS) begin
                    seq_d.phase    = PH_IDLE;
                    seq_d.ack_pend = (seq_q.kind == ST_INTA) && !seq_q.second;
                end else begin
                    seq_d.age = 1'b1;
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.phase    <= PH_IDLE;
            seq_q.kind     <= ST_PASS;
            seq_q.age      <= 1'b0;
            seq_q.second   <= 1'b0;
            seq_q.ack_pend <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign in_xfer = (seq_q.phase == PH_XFER);
    assign cmd_ok  = cmd_qual && (io_bus_mode || settle_ready);
    assign de_raw  = in_xfer && dec.xfer && (!dec.rx || seq_q.age);

    assign ale      = (seq_q.phase == PH_ADDR);
    assign mem_rd   = in_xfer && dec.mem_rd && cmd_ok;
    assign mem_wr   = in_xfer && dec.mem_wr && cmd_ok;
    assign io_rd    = in_xfer && dec.io_rd  && cmd_ok;
    assign io_wr    = in_xfer && dec.io_wr  && cmd_ok;
    assign int_ack  = in_xfer && dec.inta   && cmd_ok;
    assign cmd_oe   = io_bus_mode || !bus_release;
    assign xcvr_en  = de_raw && cmd_ok && (!io_bus_mode || !dec.io_side);
    assign xcvr_dir = !((seq_q.phase != PH_IDLE) && dec.rx);
    assign cas_or_pden = io_bus_mode ? (de_raw && cmd_ok && dec.io_side)
                                     : (ale && (seq_q.kind == ST_INTA) && seq_q.second);

    // R2: never two commands at once
    a_r2_cmd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr, io_rd, io_wr, int_ack}));

    // R5: qualifier low blocks every command and data enable
    a_r5_qual_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_qual |-> ({mem_rd, mem_wr, io_rd, io_wr, int_ack, xcvr_en} == 6'b0));

    // R1: the latch pulse lasts one clock
    a_r1_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R8: cascade enable only appears with the latch pulse
    a_r8_cas_with_ale: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_bus_mode && cas_or_pden) |-> ale);

    // R6: release in system-bus mode takes the commands off
    a_r6_release_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_bus_mode && bus_release) |->
        (!cmd_oe && ({mem_rd, mem_wr, io_rd, io_wr, int_ack, xcvr_en} == 6'b0)));
endmodule

// File: tb/bus_cmd_gen_tb_top.sv
module bus_cmd_gen_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] status = 3'b111;
    logic io_bus_mode = 1'b0;
    logic bus_release = 1'b0;
    logic cmd_qual = 1'b1;
    logic ale, mem_rd, mem_wr, io_rd, io_wr, int_ack, cmd_oe, xcvr_en, xcvr_dir, cas_or_pden;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    bus_cmd_gen dut_i (
        .clk(clk), .rst_n(rst_n), .status(status), .io_bus_mode(io_bus_mode),
        .bus_release(bus_release), .cmd_qual(cmd_qual), .ale(ale), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .int_ack(int_ack),
        .cmd_oe(cmd_oe), .xcvr_en(xcvr_en), .xcvr_dir(xcvr_dir), .cas_or_pden(cas_or_pden)
    );

    // order: ale mem_rd mem_wr io_rd io_wr int_ack cmd_oe xcvr_en xcvr_dir cas_or_pden
    function automatic logic [9:0] outs();
        return {ale, mem_rd, mem_wr, io_rd, io_wr, int_ack, cmd_oe, xcvr_en, xcvr_dir, cas_or_pden};
    endfunction

    task automatic chk(string req, logic [9:0] act, logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs actual=%b expected=%b", req, act, exp);
        end
    endtask

    localparam logic [9:0] IDLE_V = 10'b0000001010;

    // ph: 0 latch clock, 1 transfer clock
    function automatic logic [9:0] expect_v(logic [2:0] code, int ph, int k,
                                            logic io, logic second, logic qual);
        logic rx, wr, io_side, mem_side, de;
        logic [4:0] cmd;
        rx = (code == 3'b000) || (code == 3'b001) || (code == 3'b100) || (code == 3'b101);
        wr = (code == 3'b010) || (code == 3'b110);
        io_side = (code == 3'b000) || (code == 3'b001) || (code == 3'b010);
        mem_side = (code == 3'b100) || (code == 3'b101) || (code == 3'b110);
        if (ph == 0)
            return {1'b1, 5'b0, 1'b1, 1'b0, !rx, (!io && code == 3'b000 && second)};
        case (code)
            3'b101, 3'b100: cmd = 5'b10000;
            3'b110:         cmd = 5'b01000;
            3'b001:         cmd = 5'b00100;
            3'b010:         cmd = 5'b00010;
            3'b000:         cmd = 5'b00001;
            default:        cmd = 5'b00000;
        endcase
        if (!qual) cmd = 5'b0;
        de = qual && (wr || (rx && k >= 1));
        return {1'b0, cmd, 1'b1, de && (!io || mem_side), !rx, io && de && io_side};
    endfunction

    task automatic run_cyc(string req, logic [2:0] code, int nx, logic second);
        status = code;
        @(negedge clk);
        chk(req, outs(), expect_v(code, 0, 0, io_bus_mode, second, cmd_qual));
        for (int k = 0; k < nx; k++) begin
            @(negedge clk);
            chk(req, outs(), expect_v(code, 1, k, io_bus_mode, second, cmd_qual));
        end
        status = 3'b111;
        @(negedge clk);
        chk(req, outs(), IDLE_V);
    endtask

    task automatic t_reset();
        #1;
        chk("R10 in reset", outs(), IDLE_V);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R10 after reset", outs(), IDLE_V);
    endtask

    task automatic t_basic();
        run_cyc("R1 R2 R3 R4 memory read", 3'b101, 3, 1'b0);
        run_cyc("R2 R3 R4 memory write", 3'b110, 2, 1'b0);
        run_cyc("R2 R3 R4 I/O read", 3'b001, 2, 1'b0);
        run_cyc("R2 R4 I/O write", 3'b010, 2, 1'b0);
        run_cyc("R2 code fetch as memory read", 3'b100, 2, 1'b0);
        run_cyc("R2 halt gives no command", 3'b011, 2, 1'b0);
    endtask

    task automatic t_qual();
        cmd_qual = 1'b0;
        run_cyc("R5 qualifier low", 3'b110, 2, 1'b0);
        cmd_qual = 1'b1;
    endtask

    task automatic t_ack();
        run_cyc("R8 first acknowledge", 3'b000, 2, 1'b0);
        run_cyc("R8 second acknowledge", 3'b000, 2, 1'b1);
        run_cyc("R8 next pair first", 3'b000, 2, 1'b0);
        run_cyc("R8 broken by read", 3'b101, 2, 1'b0);
        run_cyc("R8 first after break", 3'b000, 2, 1'b0);
    endtask

    task automatic t_release();
        bus_release = 1'b1;
        #1;
        chk("R6 release drops cmd_oe", outs(), 10'b0000000010);
        status = 3'b101;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk("R6 read held while released", outs(), 10'b0000000000);
        bus_release = 1'b0;
        @(negedge clk);
        chk("R7 one clock after release falls", outs(), 10'b0000001000);
        @(negedge clk);
        chk("R7 commands resume at second clock", outs(), 10'b0100001100);
        status = 3'b111;
        @(negedge clk);
        chk("R7 cycle ends", outs(), IDLE_V);
    endtask

    task automatic t_iomode();
        io_bus_mode = 1'b1;
        bus_release = 1'b1;
        #1;
        chk("R9 cmd_oe kept in I/O-bus mode", outs(), IDLE_V);
        run_cyc("R9 I/O read data enable on dual pin", 3'b001, 2, 1'b0);
        run_cyc("R9 memory write on transceiver enable", 3'b110, 2, 1'b0);
        run_cyc("R9 acknowledge, no cascade", 3'b000, 2, 1'b0);
        run_cyc("R9 second acknowledge, no cascade", 3'b000, 2, 1'b1);
        bus_release = 1'b0;
        io_bus_mode = 1'b0;
    endtask

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_qual();
        t_ack();
        t_release();
        @(negedge clk); @(negedge clk); @(negedge clk);
        run_cyc("R7 settled read", 3'b101, 2, 1'b0);
        t_iomode();
        @(negedge clk); @(negedge clk); @(negedge clk);
        run_cyc("R1 back in system-bus mode", 3'b010, 1, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule